// File: doc/BRIEF.md
# Streaming Page ECC Generator

This block watches a byte-wide data stream headed to or from a NAND-flash page and builds Hamming-style check codes on the fly, so that a single flipped bit in a block can later be located and corrected, and a double flip detected. A 24-bit code is built from two kinds of parity. Line parity folds each byte's XOR-reduced value into pairs chosen by the byte's position in the block. Column parity folds each data bit into pairs chosen by its bit position inside the byte.

A mode input chooses between two layouts. In split mode, two codes are produced, one for each consecutive 256-byte block. In whole mode, one code covers a 512-byte block. Each code register is written once, on the cycle its block's last byte is accepted, and its done flag is raised then. After the final code of the chosen mode is written, the block locks and ignores further traffic until a restart strobe clears it. Codes are stored inverted, with unused bits set to one, so an erased page of all-ones bytes yields an all-ones code. The mode input is expected to be held steady between restarts.

Top module: `page_ecc_gen`

## Requirements
- R1: After reset or a restart strobe, both code outputs read all ones and both done flags are low.
- R2: Code bit 2k is the inverted XOR of the row parities (XOR of all 8 data bits) of bytes whose in-block index has bit k clear, and bit 2k+1 is the same for bytes whose index bit k is set. k runs 0..7 in split mode and 0..8 in whole mode.
- R3: Code bit 18+2j is the inverted XOR over all bytes of data bits whose bit position has bit j clear, and bit 19+2j is the same for positions with bit j set, for j = 0..2.
- R4: In split mode, code A and done A change on the clock edge that accepts byte 255 and hold the code of bytes 0..255.
- R5: In split mode, code B and done B change on the clock edge that accepts byte 511 and hold the code of bytes 256..511; code B bits 17:16 read one, as do code A bits 17:16.
- R6: In whole mode, code A and done A change on the edge that accepts byte 511 and hold the code of bytes 0..511; code B stays all ones and done B stays low.
- R7: After the final code of the mode is written, further bytes change no code output or done flag until the next restart.
- R8: A restart strobe discards the partial accumulation and restarts at byte zero; a byte presented in the same cycle as the strobe is dropped.
- R9: Cycles with the valid strobe low do not advance the byte position or the parities, whatever the data input holds.
- R10: A block of all-ones bytes yields an all-ones code.
- R11: Flipping a single data bit in a 256-byte split-mode block changes exactly 11 bits of that block's code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Restart strobe: clears codes, flags and position |
| mode_i | input | 1 | 0: two 256-byte codes, 1: one 512-byte code |
| valid_i | input | 1 | Byte on data_i is taken this cycle |
| data_i | input | 8 | Stream byte |
| code_a_o | output | 24 | First code register |
| code_b_o | output | 24 | Second code register (split mode only) |
| done_a_o | output | 1 | Code A has been written |
| done_b_o | output | 1 | Code B has been written |

## Verification
The main function is driven with an erased page, a pseudo-random page streamed back to back, the same page with idle gaps carrying junk data, and a copy with one bit flipped. The erased page tells apart the storage inversion and padding; the pseudo-random page separates line from column parity and each index bit's pair; the gapped stream shows idle cycles are not counted; and the single flip shows that exactly one bit per parity pair moves. Extra bytes after completion and a restart in mid-block, with a byte presented alongside it, cover locking and restart.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W = 8;
  localparam int COL_W  = $clog2(DATA_W);

  // bit positions of a byte whose index bit j equals odd
  function automatic logic [DATA_W-1:0] col_mask(input int j, input logic odd);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < DATA_W; b++) m[b] = (((b >> j) & 1) == int'(odd));
    return m;
  endfunction
endpackage

// File: rtl/ecc_term.sv
module ecc_term
  import ecc_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int CODE_W = 2 * IDX_W + 2 * COL_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [CODE_W-1:0] term_o
);
  logic row;
  assign row = ^data_i;

  for (genvar k = 0; k < IDX_W; k++) begin : g_line
    assign term_o[2*k]   = row & ~idx_i[k];
    assign term_o[2*k+1] = row &  idx_i[k];
  end

  for (genvar j = 0; j < COL_W; j++) begin : g_col
    assign term_o[2*IDX_W+2*j]   = ^(data_i & col_mask(j, 1'b0));
    assign term_o[2*IDX_W+2*j+1] = ^(data_i & col_mask(j, 1'b1));
  end
endmodule

// File: rtl/ecc_ctrl.sv
module ecc_ctrl #(
  parameter int BLK_W = 8,
  parameter int IDX_W = BLK_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             mode_i,
  input  logic             valid_i,
  output logic             take_o,
  output logic             end_a_o,
  output logic             end_b_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] cnt_q;
  logic             lock_q;
  logic             blk_last, page_last;

  assign take_o    = valid_i & ~lock_q & ~clr_i;
  assign blk_last  = &cnt_q[BLK_W-1:0];
  assign page_last = &cnt_q;
  assign end_a_o   = take_o & (mode_i ? page_last : (blk_last & ~cnt_q[IDX_W-1]));
  assign end_b_o   = take_o & ~mode_i & page_last;
  assign idx_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (take_o) begin
      cnt_q  <= cnt_q + 1'b1;
      lock_q <= page_last;
    end
  end

  a_r9_idle_holds_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> $stable(cnt_q));
  a_r7_lock_holds_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !clr_i) |=> (lock_q && $stable(cnt_q)));
endmodule

// File: rtl/page_ecc_gen.sv
module page_ecc_gen
  import ecc_pkg::*;
#(
  parameter int BLK_BYTES = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        mode_i,
  input  logic        valid_i,
  input  logic [7:0]  data_i,
  output logic [23:0] code_a_o,
  output logic [23:0] code_b_o,
  output logic        done_a_o,
  output logic        done_b_o
);
  localparam int BLK_W  = $clog2(BLK_BYTES);
  localparam int IDX_W  = BLK_W + 1;
  localparam int CODE_W = 2 * IDX_W + 2 * COL_W;
  // line bits that only whole mode uses; padded to one in split mode
  localparam logic [CODE_W-1:0] SPLIT_PAD =
    {{(2*COL_W){1'b0}}, {(2*(IDX_W-BLK_W)){1'b1}}, {(2*BLK_W){1'b0}}};

  logic              take, end_a, end_b;
  logic [IDX_W-1:0]  idx;
  logic [CODE_W-1:0] term, acc_q, acc_nxt, code_nxt;
  logic [CODE_W-1:0] code_a_q, code_b_q;
  logic              done_a_q, done_b_q;

  ecc_ctrl #(.BLK_W(BLK_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni, .clr_i, .mode_i, .valid_i,
    .take_o(take), .end_a_o(end_a), .end_b_o(end_b), .idx_o(idx)
  );

  ecc_term #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_term (
    .data_i(data_i), .idx_i(idx), .term_o(term)
  );

  assign acc_nxt  = acc_q ^ term;
  assign code_nxt = ~acc_nxt | (mode_i ? '0 : SPLIT_PAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      code_a_q <= '1;
      code_b_q <= '1;
      done_a_q <= 1'b0;
      done_b_q <= 1'b0;
    end else if (clr_i) begin
      acc_q    <= '0;
      code_a_q <= '1;
      code_b_q <= '1;
      done_a_q <= 1'b0;
      done_b_q <= 1'b0;
    end else if (take) begin
      acc_q <= (end_a | end_b) ? '0 : acc_nxt;
      if (end_a) begin
        code_a_q <= code_nxt;
        done_a_q <= 1'b1;
      end
      if (end_b) begin
        code_b_q <= code_nxt;
        done_b_q <= 1'b1;
      end
    end
  end

  assign code_a_o = code_a_q;
  assign code_b_o = code_b_q;
  assign done_a_o = done_a_q;
  assign done_b_o = done_b_q;

  a_r8_clr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!done_a_o && !done_b_o && (&code_a_o) && (&code_b_o)));
  a_r5_b_after_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_b_o |-> done_a_o);
  a_r7_codes_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((done_b_o || (mode_i && done_a_o)) && !clr_i) |=>
      ($stable(code_a_o) && $stable(code_b_o) && done_a_o));
  a_r4_done_a_on_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_a_o) |-> $past(valid_i));
  a_r6_b_idle_whole: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && $stable(mode_i) && !done_b_o) |=> !done_b_o);
endmodule

// File: tb/page_ecc_gen_tb.sv
module page_ecc_gen_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        mode = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  data = '0;
  logic [23:0] code_a, code_b;
  logic        done_a, done_b;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;
  logic [7:0] pg [512];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_ecc_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .mode_i(mode), .valid_i(valid),
    .data_i(data), .code_a_o(code_a), .code_b_o(code_b),
    .done_a_o(done_a), .done_b_o(done_b)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_code(input int base, input int n, input int ibits);
    logic [23:0] raw = '0;
    logic [23:0] c;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = pg[base+i];
      if (^d) for (int k = 0; k < ibits; k++) raw[2*k + ((i >> k) & 1)] ^= 1'b1;
      for (int j = 0; j < 3; j++)
        for (int b = 0; b < 8; b++)
          if (d[b]) raw[18 + 2*j + ((b >> j) & 1)] ^= 1'b1;
    end
    c = ~raw;
    for (int k = ibits; k < 9; k++) c[2*k +: 2] = 2'b11;
    return c;
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < 512; i++) pg[i] = 8'((i * 37 + seed) ^ (i >> 3) ^ (seed * i >> 5));
  endtask

  task automatic restart();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic stream(input int base, input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 7 == 3)) begin
        valid = 1'b0; data = 8'(~pg[base+i]);
        @(negedge clk);
      end
      valid = 1'b1; data = pg[base+i];
      @(negedge clk);
    end
    valid = 1'b0;
  endtask

  task automatic t_reset();
    check(code_a === 24'hFFFFFF, "R1 reset code_a", code_a, 24'hFFFFFF);
    check(code_b === 24'hFFFFFF, "R1 reset code_b", code_b, 24'hFFFFFF);
    check(!done_a && !done_b, "R1 reset done", {22'd0, done_a, done_b}, 24'd0);
  endtask

  task automatic t_erased();
    for (int i = 0; i < 512; i++) pg[i] = 8'hFF;
    mode = 1'b0; restart();
    stream(0, 512, 0);
    check(code_a === 24'hFFFFFF, "R10 erased code_a", code_a, 24'hFFFFFF);
    check(code_b === 24'hFFFFFF, "R10 erased code_b", code_b, 24'hFFFFFF);
  endtask

  task automatic t_split();
    logic [23:0] ea, eb;
    fill(11); mode = 1'b0; restart();
    ea = ref_code(0, 256, 8); eb = ref_code(256, 256, 8);
    stream(0, 255, 0);
    check(!done_a && code_a === 24'hFFFFFF, "R4 before byte 255", code_a, 24'hFFFFFF);
    stream(255, 1, 0);
    check(done_a && code_a === ea, "R4 R2 R3 split code_a", code_a, ea);
    check(!done_b, "R5 done_b early", {23'd0, done_b}, 24'd0);
    stream(256, 256, 0);
    check(done_b && code_b === eb, "R5 split code_b", code_b, eb);
    check(code_a[17:16] == 2'b11 && code_b[17:16] == 2'b11, "R5 pad bits", {code_a[17:16], code_b[17:16]}, 24'hF);
  endtask

  task automatic t_whole_lock();
    logic [23:0] ea;
    fill(5); mode = 1'b1; restart();
    ea = ref_code(0, 512, 9);
    stream(0, 511, 0);
    check(!done_a, "R6 before byte 511", {23'd0, done_a}, 24'd0);
    stream(511, 1, 0);
    check(done_a && code_a === ea, "R6 R2 whole code_a", code_a, ea);
    check(!done_b && code_b === 24'hFFFFFF, "R6 code_b idle", code_b, 24'hFFFFFF);
    fill(99);
    stream(0, 300, 0);
    check(done_a && code_a === ea, "R7 locked code_a", code_a, ea);
    check(!done_b && code_b === 24'hFFFFFF, "R7 locked code_b", code_b, 24'hFFFFFF);
    restart();
    check(!done_a && code_a === 24'hFFFFFF, "R1 after restart", code_a, 24'hFFFFFF);
  endtask

  task automatic t_split_lock();
    logic [23:0] ea, eb;
    fill(21); mode = 1'b0; restart();
    ea = ref_code(0, 256, 8); eb = ref_code(256, 256, 8);
    stream(0, 512, 0);
    fill(77);
    stream(0, 600, 0);
    check(code_a === ea && code_b === eb && done_b, "R7 split locked", code_b, eb);
  endtask

  task automatic t_gaps();
    logic [23:0] ea, eb;
    fill(3); mode = 1'b0; restart();
    ea = ref_code(0, 256, 8); eb = ref_code(256, 256, 8);
    stream(0, 512, 1);
    check(code_a === ea, "R9 gapped code_a", code_a, ea);
    check(code_b === eb, "R9 gapped code_b", code_b, eb);
  endtask

  task automatic t_clear_mid();
    logic [23:0] ea;
    fill(42); mode = 1'b0; restart();
    stream(0, 100, 0);
    clr = 1'b1; valid = 1'b1; data = 8'h5A;
    @(negedge clk);
    clr = 1'b0; valid = 1'b0;
    ea = ref_code(0, 256, 8);
    stream(0, 256, 0);
    check(done_a && code_a === ea, "R8 restart mid block", code_a, ea);
  endtask

  task automatic t_flip();
    logic [23:0] c0, c1;
    fill(8); mode = 1'b0; restart();
    stream(0, 256, 0);
    c0 = code_a;
    pg[77] ^= 8'h10;
    restart();
    stream(0, 256, 0);
    c1 = code_a;
    check($countones(c0 ^ c1) == 11, "R11 single flip distance", 24'($countones(c0 ^ c1)), 24'd11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_erased();
    t_split();
    t_whole_lock();
    t_split_lock();
    t_gaps();
    t_clear_mid();
    t_flip();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule